// File: doc/BRIEF.md
# PCI Read Initiator Sequencer

This block runs the initiator side of a read on a multiplexed address/data bus in the style of PCI. A local client hands it one request: a start address, a command code, the number of beats minus one, and one byte-enable nibble per beat. The block then sequences the bus. It drives the address and command for one clock and then lets go of the shared AD lines so the target can turn them around. Through every data phase it asserts initiator-ready and drives that beat's byte enables. It negates its frame output in the final data phase only.

Each word the target returns is registered onto a local data output together with a one-clock valid strobe. When the final word has moved, the block drops initiator-ready, releases the command/byte-enable lines, pulses `done_o` and goes idle. If no target claims the cycle within a bounded number of clocks, the block abandons the read and pulses an error flag. Bus signals use active-low polarity. Each driven bus group has a separate output-enable, so a pad ring or a bus model can tri-state it.

Top module: `pci_read_initiator`

## Requirements
- R1: A request accepted while idle starts the next clock with an address phase. In that clock `frame_n_o` is low, `irdy_n_o` is high, `ad_oe_o` is high with `ad_out_o` equal to the request address, and `cbe_oe_o` is high with `cbe_out_o` equal to the request command.
- R2: In every data-phase clock `ad_oe_o` is low, which leaves AD free for the target after the turnaround.
- R3: In every data-phase clock `cbe_oe_o` is high and `cbe_out_o` carries the byte-enable nibble of the current beat. Beat k uses bits [4k+3:4k] of `req_be_i`, and the value is passed through without change.
- R4: A word moves only on a rising edge where both `irdy_n_o` and `trdy_n_i` are low. The clock after such an edge, `rd_valid_o` is high and `rd_data_o` holds the AD value sampled at that edge. A data-phase clock with `trdy_n_i` high is a wait and advances nothing.
- R5: `frame_n_o` stays low through every data phase except the last one. In the last data phase it is high while `irdy_n_o` stays low. For a single-beat read that is the first data phase.
- R6: `req_last_i` holds the beat count minus one, so values 0 to MAX_BEATS-1 give 1 to MAX_BEATS beats.
- R7: The clock after the final transfer, `irdy_n_o` and `frame_n_o` are high, `cbe_oe_o` is low and `done_o` is high for exactly that one clock. The block is then idle.
- R8: If `devsel_n_i` has not been low on any of the first DEVSEL_TIMEOUT data-phase edges, the block aborts on that edge. The following clock shows `timeout_err_o` high for one clock, with `done_o` and `rd_valid_o` low, all bus outputs released and the block idle.
- R9: A request presented while the block is busy is not accepted. Dropping it before the block returns to idle leaves no transaction behind.
- R10: During and right after reset the block is idle: `frame_n_o` and `irdy_n_o` high, both output-enables low, and `done_o`, `rd_valid_o`, `timeout_err_o` and `busy_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Read request present |
| req_addr_i | input | DATA_W | Start address |
| req_cmd_i | input | DATA_W/8 | Command code driven in the address phase |
| req_last_i | input | log2(MAX_BEATS) | Beat count minus one |
| req_be_i | input | MAX_BEATS*DATA_W/8 | Byte-enable nibble per beat, beat 0 in the low bits |
| busy_o | output | 1 | A transaction is in progress |
| ad_in_i | input | DATA_W | Sampled AD lines |
| ad_out_o | output | DATA_W | Value driven onto AD |
| ad_oe_o | output | 1 | AD output-enable |
| cbe_out_o | output | DATA_W/8 | Value driven onto command/byte-enable lines |
| cbe_oe_o | output | 1 | Command/byte-enable output-enable |
| frame_n_o | output | 1 | Frame, active low |
| irdy_n_o | output | 1 | Initiator ready, active low |
| devsel_n_i | input | 1 | Device select from target, active low |
| trdy_n_i | input | 1 | Target ready, active low |
| rd_data_o | output | DATA_W | Last word captured |
| rd_valid_o | output | 1 | One-clock strobe for a new word in rd_data_o |
| done_o | output | 1 | One-clock pulse after the final transfer |
| timeout_err_o | output | 1 | One-clock pulse on a device-select timeout |

## Verification
The bench targets the single-beat read, where frame must already be high in the first data phase. A design that counts beats off by one would hold frame low for an extra phase and request a second word. Target waits are interleaved at several positions, including the final beat. This catches a design that advances the beat index or strobes valid on a wait cycle, which shows up as wrong byte enables or a doubled word. Device-select arrives on the last permitted edge in one case and never in another. Together these pin the timeout limit: an off-by-one aborts a legal read or lingers an extra clock. The bench also holds a request across a whole transaction to expose a sequencer that queues or re-launches it.

// File: rtl/pci_rd_pkg.sv
package pci_rd_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ADDR = 2'd1,
      ST_DATA = 2'd2
   } rd_state_e;

endpackage

// File: rtl/pci_rd_ctrl.sv
module pci_rd_ctrl
   import pci_rd_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CMD_W  = 4,
   parameter int LEN_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [DATA_W-1:0] req_addr,
   input  logic [CMD_W-1:0]  req_cmd,
   input  logic [LEN_W-1:0]  req_last,
   input  logic              trdy_n,
   input  logic              expire,
   output rd_state_e         state_o,
   output logic [DATA_W-1:0] addr_o,
   output logic [CMD_W-1:0]  cmd_o,
   output logic [LEN_W-1:0]  beat_o,
   output logic              final_beat_o,
   output logic              load_o,
   output logic              xfer_o,
   output logic              done_o,
   output logic              err_o
);

   rd_state_e         state_q;
   logic [DATA_W-1:0] addr_q;
   logic [CMD_W-1:0]  cmd_q;
   logic [LEN_W-1:0]  last_q;
   logic [LEN_W-1:0]  beat_q;
   logic              done_q;
   logic              err_q;

   assign load_o       = (state_q == ST_IDLE) && req_valid;
   assign xfer_o       = (state_q == ST_DATA) && !trdy_n;
   assign final_beat_o = (beat_q == last_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         addr_q  <= '0;
         cmd_q   <= '0;
         last_q  <= '0;
         beat_q  <= '0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  addr_q  <= req_addr;
                  cmd_q   <= req_cmd;
                  last_q  <= req_last;
                  state_q <= ST_ADDR;
               end
            end
            ST_ADDR: begin
               beat_q  <= '0;
               state_q <= ST_DATA;
            end
            ST_DATA: begin
               if (!trdy_n) begin
                  if (beat_q == last_q) begin
                     state_q <= ST_IDLE;
                     done_q  <= 1'b1;
                  end else begin
                     beat_q <= beat_q + 1'b1;
                  end
               end else if (expire) begin
                  state_q <= ST_IDLE;
                  err_q   <= 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign state_o = state_q;
   assign addr_o  = addr_q;
   assign cmd_o   = cmd_q;
   assign beat_o  = beat_q;
   assign done_o  = done_q;
   assign err_o   = err_q;

endmodule

// File: rtl/pci_rd_devsel_timer.sv
module pci_rd_devsel_timer #(
   parameter int LIMIT = 5,
   parameter int CNT_W = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic devsel_n,
   output logic expire
);

   logic [CNT_W-1:0] cnt_q;
   logic             seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         seen_q <= 1'b0;
      end else if (!active) begin
         cnt_q  <= '0;
         seen_q <= 1'b0;
      end else if (!devsel_n) begin
         seen_q <= 1'b1;
      end else if (!seen_q) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign expire = active && !seen_q && devsel_n && (cnt_q == CNT_W'(LIMIT - 1));

endmodule

// File: rtl/pci_rd_be_sel.sv
module pci_rd_be_sel #(
   parameter int BE_W      = 4,
   parameter int MAX_BEATS = 8,
   parameter int LEN_W     = 3
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      load,
   input  logic [MAX_BEATS*BE_W-1:0] be_flat,
   input  logic [LEN_W-1:0]          beat,
   output logic [BE_W-1:0]           be_o
);

   logic [BE_W-1:0] lane_be [MAX_BEATS];

   for (genvar g = 0; g < MAX_BEATS; g++) begin : g_slot
      logic [BE_W-1:0] slot_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    slot_q <= '0;
         else if (load) slot_q <= be_flat[g*BE_W +: BE_W];
      end
      assign lane_be[g] = slot_q;
   end

   assign be_o = lane_be[beat];

endmodule

// File: rtl/pci_rd_capture.sv
module pci_rd_capture #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              xfer,
   input  logic [DATA_W-1:0] ad_in,
   output logic [DATA_W-1:0] data_o,
   output logic              valid_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_o  <= '0;
         valid_o <= 1'b0;
      end else begin
         valid_o <= xfer;
         if (xfer) data_o <= ad_in;
      end
   end

endmodule

// File: rtl/pci_read_initiator.sv
module pci_read_initiator
   import pci_rd_pkg::*;
#(
   parameter int  DATA_W         = 32,
   parameter int  MAX_BEATS      = 8,
   parameter int  DEVSEL_TIMEOUT = 5,
   localparam int BE_W           = DATA_W / 8,
   localparam int LEN_W          = $clog2(MAX_BEATS)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      req_valid_i,
   input  logic [DATA_W-1:0]         req_addr_i,
   input  logic [BE_W-1:0]           req_cmd_i,
   input  logic [LEN_W-1:0]          req_last_i,
   input  logic [MAX_BEATS*BE_W-1:0] req_be_i,
   output logic                      busy_o,
   input  logic [DATA_W-1:0]         ad_in_i,
   output logic [DATA_W-1:0]         ad_out_o,
   output logic                      ad_oe_o,
   output logic [BE_W-1:0]           cbe_out_o,
   output logic                      cbe_oe_o,
   output logic                      frame_n_o,
   output logic                      irdy_n_o,
   input  logic                      devsel_n_i,
   input  logic                      trdy_n_i,
   output logic [DATA_W-1:0]         rd_data_o,
   output logic                      rd_valid_o,
   output logic                      done_o,
   output logic                      timeout_err_o
);

   localparam int TMR_W = $clog2(DEVSEL_TIMEOUT + 1);

   if (DATA_W < 16 || (DATA_W % 8) != 0) begin : g_bad_width
      $error("DATA_W must be a multiple of 8 and at least 16");
   end
   if (MAX_BEATS < 2 || (MAX_BEATS & (MAX_BEATS - 1)) != 0) begin : g_bad_beats
      $error("MAX_BEATS must be a power of two of at least 2");
   end
   if (DEVSEL_TIMEOUT < 2) begin : g_bad_timeout
      $error("DEVSEL_TIMEOUT must be at least 2");
   end

   rd_state_e         state;
   logic [DATA_W-1:0] addr_q;
   logic [BE_W-1:0]   cmd_q;
   logic [LEN_W-1:0]  beat;
   logic              final_beat;
   logic              load;
   logic              xfer;
   logic              expire;
   logic [BE_W-1:0]   be_cur;
   logic              in_addr;
   logic              in_data;

   pci_rd_ctrl #(
      .DATA_W (DATA_W),
      .CMD_W  (BE_W),
      .LEN_W  (LEN_W)
   ) i_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid_i),
      .req_addr     (req_addr_i),
      .req_cmd      (req_cmd_i),
      .req_last     (req_last_i),
      .trdy_n       (trdy_n_i),
      .expire       (expire),
      .state_o      (state),
      .addr_o       (addr_q),
      .cmd_o        (cmd_q),
      .beat_o       (beat),
      .final_beat_o (final_beat),
      .load_o       (load),
      .xfer_o       (xfer),
      .done_o       (done_o),
      .err_o        (timeout_err_o)
   );

   pci_rd_devsel_timer #(
      .LIMIT (DEVSEL_TIMEOUT),
      .CNT_W (TMR_W)
   ) i_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .active   (in_data),
      .devsel_n (devsel_n_i),
      .expire   (expire)
   );

   pci_rd_be_sel #(
      .BE_W      (BE_W),
      .MAX_BEATS (MAX_BEATS),
      .LEN_W     (LEN_W)
   ) i_be_sel (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .be_flat (req_be_i),
      .beat    (beat),
      .be_o    (be_cur)
   );

   pci_rd_capture #(
      .DATA_W (DATA_W)
   ) i_capture (
      .clk     (clk),
      .rst_n   (rst_n),
      .xfer    (xfer),
      .ad_in   (ad_in_i),
      .data_o  (rd_data_o),
      .valid_o (rd_valid_o)
   );

   assign in_addr = (state == ST_ADDR);
   assign in_data = (state == ST_DATA);

   always_comb begin
      busy_o    = (state != ST_IDLE);
      ad_oe_o   = in_addr;
      ad_out_o  = in_addr ? addr_q : '0;
      cbe_oe_o  = in_addr || in_data;
      cbe_out_o = in_addr ? cmd_q : (in_data ? be_cur : '0);
      frame_n_o = !(in_addr || (in_data && !final_beat));
      irdy_n_o  = !in_data;
   end

endmodule

// File: rtl/pci_read_initiator_chk.sv
module pci_read_initiator_chk #(
   parameter int  DATA_W         = 32,
   parameter int  MAX_BEATS      = 8,
   parameter int  DEVSEL_TIMEOUT = 5,
   localparam int BE_W           = DATA_W / 8,
   localparam int LEN_W          = $clog2(MAX_BEATS)
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      req_valid_i,
   input logic [DATA_W-1:0]         req_addr_i,
   input logic [BE_W-1:0]           req_cmd_i,
   input logic [LEN_W-1:0]          req_last_i,
   input logic [MAX_BEATS*BE_W-1:0] req_be_i,
   input logic                      busy_o,
   input logic [DATA_W-1:0]         ad_in_i,
   input logic [DATA_W-1:0]         ad_out_o,
   input logic                      ad_oe_o,
   input logic [BE_W-1:0]           cbe_out_o,
   input logic                      cbe_oe_o,
   input logic                      frame_n_o,
   input logic                      irdy_n_o,
   input logic                      devsel_n_i,
   input logic                      trdy_n_i,
   input logic [DATA_W-1:0]         rd_data_o,
   input logic                      rd_valid_o,
   input logic                      done_o,
   input logic                      timeout_err_o
);

   // R1
   addr_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(frame_n_o) |-> (ad_oe_o && cbe_oe_o && irdy_n_o));

   // R2
   ad_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !irdy_n_o |-> !ad_oe_o);

   // R3
   be_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !irdy_n_o |-> cbe_oe_o);

   // R4
   capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!irdy_n_o && !trdy_n_i) |=> (rd_valid_o && rd_data_o == $past(ad_in_i)));

   // R5
   last_phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!irdy_n_o && !frame_n_o && trdy_n_i && !devsel_n_i) |=> (!irdy_n_o && !frame_n_o));

   // R7
   release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!irdy_n_o && frame_n_o && !trdy_n_i) |=> (irdy_n_o && !cbe_oe_o && done_o && !busy_o));

   // R8
   timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_err_o |-> ($past(devsel_n_i) && irdy_n_o && frame_n_o && !done_o && !rd_valid_o));

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

endmodule

bind pci_read_initiator pci_read_initiator_chk #(
   .DATA_W         (DATA_W),
   .MAX_BEATS      (MAX_BEATS),
   .DEVSEL_TIMEOUT (DEVSEL_TIMEOUT)
) i_chk (.*);

// File: tb/test_pci_read_initiator.sv
`timescale 1ns/1ps
module test_pci_read_initiator;

   localparam int DATA_W    = 32;
   localparam int MAX_BEATS = 8;
   localparam int TIMEOUT   = 5;
   localparam int BE_W      = DATA_W / 8;
   localparam int LEN_W     = $clog2(MAX_BEATS);

   typedef struct packed {
      logic [31:0] addr;
      logic [3:0]  cmd;
      logic [2:0]  last;
      logic [31:0] be;
      logic [2:0]  dsl;
      logic [7:0]  wmask;
   } vec_t;

   localparam int NV = 6;
   localparam vec_t VEC [NV] = '{
      '{32'h0000_1000, 4'h6, 3'd0, 32'h0000_000A, 3'd0, 8'h00},
      '{32'h8000_0040, 4'h6, 3'd3, 32'h0000_E1C3, 3'd1, 8'h05},
      '{32'h1234_5678, 4'hC, 3'd7, 32'h7654_3210, 3'd2, 8'hAA},
      '{32'hFFFF_FFFC, 4'hE, 3'd1, 32'h0000_00F0, 3'd4, 8'h00},
      '{32'h0BAD_F00C, 4'h2, 3'd0, 32'h0000_0005, 3'd3, 8'h03},
      '{32'h4000_0100, 4'h6, 3'd5, 32'h00AB_CDEF, 3'd0, 8'hF0}
   };

   logic                      clk;
   logic                      rst_n;
   logic                      req_valid_i;
   logic [DATA_W-1:0]         req_addr_i;
   logic [BE_W-1:0]           req_cmd_i;
   logic [LEN_W-1:0]          req_last_i;
   logic [MAX_BEATS*BE_W-1:0] req_be_i;
   logic                      busy_o;
   logic [DATA_W-1:0]         ad_in_i;
   logic [DATA_W-1:0]         ad_out_o;
   logic                      ad_oe_o;
   logic [BE_W-1:0]           cbe_out_o;
   logic                      cbe_oe_o;
   logic                      frame_n_o;
   logic                      irdy_n_o;
   logic                      devsel_n_i;
   logic                      trdy_n_i;
   logic [DATA_W-1:0]         rd_data_o;
   logic                      rd_valid_o;
   logic                      done_o;
   logic                      timeout_err_o;

   int n_checks = 0;
   int n_fails  = 0;

   pci_read_initiator #(
      .DATA_W         (DATA_W),
      .MAX_BEATS      (MAX_BEATS),
      .DEVSEL_TIMEOUT (TIMEOUT)
   ) i_pci_read_initiator (.*);

   initial clk = 1'b0;
   always #10 clk = ~clk;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] word_of(input logic [31:0] a, input int b);
      return (a + 32'(b) * 32'h0101_0101) ^ 32'hA5A5_0000;
   endfunction

   task automatic check_idle(input string req);
      chk(frame_n_o == 1'b1, req, "frame_n idle", 32'(frame_n_o), 32'h1);
      chk(irdy_n_o == 1'b1, req, "irdy_n idle", 32'(irdy_n_o), 32'h1);
      chk(ad_oe_o == 1'b0, req, "ad_oe idle", 32'(ad_oe_o), 32'h0);
      chk(cbe_oe_o == 1'b0, req, "cbe_oe idle", 32'(cbe_oe_o), 32'h0);
      chk(busy_o == 1'b0, req, "busy idle", 32'(busy_o), 32'h0);
   endtask

   task automatic run_txn(input logic [31:0] addr, input logic [3:0] cmd,
                          input logic [2:0] last, input logic [31:0] be,
                          input int dsl, input logic [7:0] wm, input bit hold_req);
      int  beat;
      int  cyc;
      bit  prev;
      bit  dv;
      bit  go;
      logic [31:0] pword;
      @(negedge clk);
      req_valid_i = 1'b1;
      req_addr_i  = addr;
      req_cmd_i   = cmd;
      req_last_i  = last;
      req_be_i    = be;
      @(negedge clk);
      // R1 address phase
      chk(frame_n_o == 1'b0, "R1", "frame_n in addr", 32'(frame_n_o), 32'h0);
      chk(irdy_n_o == 1'b1, "R1", "irdy_n in addr", 32'(irdy_n_o), 32'h1);
      chk(ad_oe_o && ad_out_o == addr, "R1", "address driven", ad_out_o, addr);
      chk(cbe_oe_o && cbe_out_o == cmd, "R1", "command driven", 32'(cbe_out_o), 32'(cmd));
      if (hold_req) req_addr_i = ~addr;
      else          req_valid_i = 1'b0;
      devsel_n_i = 1'b1;
      trdy_n_i   = 1'b1;
      beat = 0; cyc = 0; prev = 1'b0; pword = '0;
      while (beat <= int'(last)) begin
         @(negedge clk);
         chk(irdy_n_o == 1'b0, "R4", "irdy_n in data", 32'(irdy_n_o), 32'h0);
         chk(ad_oe_o == 1'b0, "R2", "ad released", 32'(ad_oe_o), 32'h0);
         chk(cbe_oe_o && cbe_out_o == be[beat*4 +: 4], "R3", "byte enables",
             32'(cbe_out_o), 32'(be[beat*4 +: 4]));
         chk(frame_n_o == (beat == int'(last)), "R5", "frame_n in data",
             32'(frame_n_o), 32'(beat == int'(last)));
         chk(rd_valid_o == prev, "R4", "rd_valid", 32'(rd_valid_o), 32'(prev));
         if (prev) chk(rd_data_o == pword, "R4", "rd_data", rd_data_o, pword);
         chk(done_o == 1'b0, "R7", "no early done", 32'(done_o), 32'h0);
         dv = (cyc >= dsl);
         go = dv && !wm[cyc % 8];
         devsel_n_i = !dv;
         trdy_n_i   = !go;
         ad_in_i    = word_of(addr, beat);
         prev = go;
         if (go) begin
            pword = ad_in_i;
            beat++;
         end
         cyc++;
      end
      @(negedge clk);
      devsel_n_i = 1'b1;
      trdy_n_i   = 1'b1;
      // R6 beat count: last+1 words moved
      chk(beat == int'(last) + 1, "R6", "beat count", 32'(beat), 32'(last) + 1);
      chk(rd_valid_o && rd_data_o == pword, "R4", "final word", rd_data_o, pword);
      chk(done_o == 1'b1, "R7", "done pulse", 32'(done_o), 32'h1);
      chk(timeout_err_o == 1'b0, "R8", "no timeout", 32'(timeout_err_o), 32'h0);
      check_idle("R7");
      if (hold_req) begin
         req_valid_i = 1'b0;
         for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            chk(frame_n_o == 1'b1 && busy_o == 1'b0, "R9", "held request not queued",
                32'(frame_n_o), 32'h1);
         end
      end
      @(negedge clk);
      chk(done_o == 1'b0, "R7", "done one clock", 32'(done_o), 32'h0);
   endtask

   task automatic run_timeout;
      @(negedge clk);
      req_valid_i = 1'b1;
      req_addr_i  = 32'h0000_2000;
      req_cmd_i   = 4'h6;
      req_last_i  = 3'd2;
      req_be_i    = '0;
      @(negedge clk);
      req_valid_i = 1'b0;
      devsel_n_i  = 1'b1;
      trdy_n_i    = 1'b1;
      for (int c = 0; c < TIMEOUT; c++) begin
         @(negedge clk);
         chk(irdy_n_o == 1'b0, "R8", "waiting for devsel", 32'(irdy_n_o), 32'h0);
         chk(timeout_err_o == 1'b0, "R8", "no early timeout", 32'(timeout_err_o), 32'h0);
      end
      @(negedge clk);
      chk(timeout_err_o == 1'b1, "R8", "timeout flag", 32'(timeout_err_o), 32'h1);
      chk(done_o == 1'b0 && rd_valid_o == 1'b0, "R8", "no done or data",
          32'({done_o, rd_valid_o}), 32'h0);
      check_idle("R8");
      @(negedge clk);
      chk(timeout_err_o == 1'b0, "R8", "timeout one clock", 32'(timeout_err_o), 32'h0);
   endtask

   initial begin
      #(200000 * 20);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      rst_n       = 1'b0;
      req_valid_i = 1'b0;
      req_addr_i  = '0;
      req_cmd_i   = '0;
      req_last_i  = '0;
      req_be_i    = '0;
      ad_in_i     = '0;
      devsel_n_i  = 1'b1;
      trdy_n_i    = 1'b1;
      repeat (3) @(negedge clk);
      // R10 state during reset
      check_idle("R10");
      chk(done_o == 1'b0 && rd_valid_o == 1'b0 && timeout_err_o == 1'b0, "R10",
          "pulses low in reset", 32'({done_o, rd_valid_o, timeout_err_o}), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check_idle("R10");

      for (int i = 0; i < NV; i++)
         run_txn(VEC[i].addr, VEC[i].cmd, VEC[i].last, VEC[i].be,
                 int'(VEC[i].dsl), VEC[i].wmask, 1'b0);

      // R9 request held across a transaction
      run_txn(32'h2222_0010, 4'h6, 3'd2, 32'h0000_0369, 1, 8'h02, 1'b1);
      // R8 no target answers
      run_timeout();
      // R6 maximum length right after an abort, final beat behind a wait
      run_txn(32'h7000_0000, 4'hC, 3'd7, 32'h8421_8421, 0, 8'h80, 1'b0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule